// File: doc/BRIEF.md
# Tamper-Triggered Memory Zeroization Controller

This block guards an on-chip memory that holds secrets. It watches a group of tamper sense lines, for example lid and tilt switches, a light detector and an enclosure mesh loop. When any line fires, the block takes the memory's write port and starts an erase that cannot be stopped. The erase makes several full sweeps of pseudo-random data and then one sweep of zeros. The erase runs from the block's own clock and needs nothing from a host to finish, so it also completes on backup power.

The block also sits in the host's read path. A sticky readback lock forces every host read to return zero. Software can set the lock directly, and any tamper event sets it too. Only a power-on reset clears it.

Top module: `zeroize_ctrl`

## Requirements
- R1: Any bit of `tamper_i` that is high for at least one cycle starts an erase. The input passes through two synchronizer flops. With the pulse first sampled at clock edge E0, `busy_o` and `tamper_event_o` are still low after E1 and high after E2.
- R2: `tamper_event_o` stays high from the trigger until `rst_n` is asserted, even after every tamper input returns low.
- R3: An erase issues exactly (RAND_PASSES+1)·2^ADDR_W writes, one per cycle on consecutive cycles. The first RAND_PASSES sweeps carry random data. The last sweep writes all zeros, so every location reads zero at the end.
- R4: Random data comes from a 32-bit Galois LFSR that shifts right. When the bit shifted out is 1, the new state is XORed with 0x80200003. The LFSR starts from the nonzero SEED (default 0xACE12024). The first random write carries SEED, and the LFSR advances once after each random write. After a reset it starts again from SEED.
- R5: Every sweep writes addresses 0, 1, … 2^ADDR_W−1 in ascending order, each exactly once, before the next sweep begins.
- R6: `mem_rd_addr_o` follows `host_rd_addr_i`. `host_rd_data_o` equals `mem_rd_data_i` while unlocked. It is zero from the cycle `tamper_event_o` rises, through the erase and after it, until reset.
- R7: A cycle with `rdlock_i` high makes `host_rd_data_o` zero from the next clock edge until reset. It does not start an erase and issues no memory write.
- R8: Once started, an erase cannot be aborted. Tamper pulses during or after the erase neither restart it nor add writes.
- R9: `done_o` rises on the edge after the final write and stays high until reset. `busy_o` is low from that edge on.
- R10: While `rst_n` is low, `busy_o`, `done_o`, `tamper_event_o` and `mem_we_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tamper_i | input | N_TAMPER | Asynchronous tamper sense lines, active high |
| rdlock_i | input | 1 | Sets the sticky readback lock |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | DATA_W | Memory write data |
| host_rd_addr_i | input | ADDR_W | Host read address |
| mem_rd_addr_o | output | ADDR_W | Read address to memory |
| mem_rd_data_i | input | DATA_W | Read data from memory |
| host_rd_data_o | output | DATA_W | Gated read data to host |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | Erase complete, sticky |
| tamper_event_o | output | 1 | Tamper seen since reset, sticky |

## Verification
The bench drives tamper pulses as short as one cycle on single inputs and on combinations of inputs. A synchronizer that dropped such a pulse would never erase, and one with a different latency would move the edge where `busy_o` rises. A write monitor rebuilds the LFSR sequence and the ascending address order for every write. It would catch a missing final zero sweep, a sweep that skips or repeats an address, or an LFSR that does not restart after reset. Extra tamper pulses in the middle of the erase and after it would show up as an excess write count in a design that restarts. A lock-only stimulus checks that reads go dark without any write, and that a lock which failed to hold would leak preloaded data.

// File: rtl/zrz_pkg.sv
package zrz_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_DONE} zrz_state_e;

  localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

  // One Galois step, right shifting
  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
  endfunction
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
  parameter int N_TAMPER = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_TAMPER-1:0] tamper_i,
  output logic                fire_o,
  output logic                event_o
);
  logic [N_TAMPER-1:0] s1_q, s2_q;
  logic                evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      evt_q <= 1'b0;
    end else begin
      s1_q  <= tamper_i;
      s2_q  <= s1_q;
      evt_q <= evt_q | (|s2_q);
    end
  end

  assign fire_o  = |s2_q;
  assign event_o = evt_q;

  // event latch never falls outside reset
  assert_event_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_q) |-> evt_q);
  // a synchronized pulse always leaves the latch set
  assert_fire_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> event_o);
endmodule

// File: rtl/zrz_lfsr.sv
module zrz_lfsr #(
  parameter logic [31:0] SEED = 32'hACE1_2024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_i,
  output logic [31:0] value_o
);
  import zrz_pkg::*;
  logic [31:0] st_q;

  initial begin
    assert (SEED != 32'h0) else $error("LFSR seed must be nonzero");
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= SEED;
    else if (step_i) st_q <= lfsr_next(st_q);
  end

  assign value_o = st_q;

  assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 32'h0);
  assert_lfsr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(step_i) |-> $stable(st_q));
endmodule

// File: rtl/erase_seq.sv
module erase_seq #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int RAND_PASSES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       rnd_i,
  output logic              step_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              busy_o,
  output logic              done_o
);
  import zrz_pkg::*;
  localparam int TOTAL  = RAND_PASSES + 1;
  localparam int PASS_W = $clog2(TOTAL + 1);

  zrz_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PASS_W-1:0] pass_q;

  logic active, addr_last, pass_last, final_write, rand_pass;
  assign active      = (st_q == ST_ERASE);
  assign addr_last   = (addr_q == '1);
  assign pass_last   = (pass_q == PASS_W'(TOTAL - 1));
  assign final_write = active & addr_last & pass_last;
  assign rand_pass   = (pass_q < PASS_W'(RAND_PASSES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      pass_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (start_i) st_q <= ST_ERASE;
        ST_ERASE: begin
          addr_q <= addr_q + 1'b1;
          if (addr_last) pass_q <= pass_q + 1'b1;
          if (final_write) st_q <= ST_DONE;
        end
        default:  st_q <= ST_DONE;
      endcase
    end
  end

  assign we_o    = active;
  assign addr_o  = addr_q;
  assign wdata_o = (active && rand_pass) ? DATA_W'(rnd_i) : '0;
  assign step_o  = active & rand_pass;
  assign busy_o  = active;
  assign done_o  = (st_q == ST_DONE);

  assert_addr_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) |-> addr_q == $past(addr_q) + 1'b1);
  assert_no_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active) && !$past(final_write) |-> active);
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_o) |-> done_o && !busy_o);
  assert_full_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> pass_q == PASS_W'(TOTAL) && addr_q == '0);
endmodule

// File: rtl/zeroize_ctrl.sv
module zeroize_ctrl #(
  parameter int          N_TAMPER    = 4,
  parameter int          ADDR_W      = 6,
  parameter int          DATA_W      = 32,
  parameter int          RAND_PASSES = 3,
  parameter logic [31:0] SEED        = 32'hACE1_2024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_TAMPER-1:0] tamper_i,
  input  logic                rdlock_i,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [ADDR_W-1:0]   host_rd_addr_i,
  output logic [ADDR_W-1:0]   mem_rd_addr_o,
  input  logic [DATA_W-1:0]   mem_rd_data_i,
  output logic [DATA_W-1:0]   host_rd_data_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                tamper_event_o
);
  logic        fire, evt, step;
  logic [31:0] rnd;
  logic        lock_q, locked;

  tamper_sync #(.N_TAMPER(N_TAMPER)) u_sync (
    .clk(clk), .rst_n(rst_n), .tamper_i(tamper_i),
    .fire_o(fire), .event_o(evt));

  zrz_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step_i(step), .value_o(rnd));

  erase_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAND_PASSES(RAND_PASSES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(fire), .rnd_i(rnd), .step_o(step),
    .we_o(mem_we_o), .addr_o(mem_addr_o), .wdata_o(mem_wdata_o),
    .busy_o(busy_o), .done_o(done_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_q | rdlock_i;
  end

  assign locked         = lock_q | evt;
  assign mem_rd_addr_o  = host_rd_addr_i;
  assign host_rd_data_o = locked ? '0 : mem_rd_data_i;
  assign tamper_event_o = evt;

  // erase start and event latch move together
  assert_start_with_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> tamper_event_o);
  assert_read_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tamper_event_o || busy_o || done_o) |-> host_rd_data_o == '0);
  assert_lock_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> tamper_event_o);
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> locked);
endmodule

// File: tb/tb_zeroize_ctrl.sv
module tb_zeroize_ctrl;
  localparam int          NT    = 4;
  localparam int          AW    = 6;
  localparam int          DW    = 32;
  localparam int          RP    = 3;
  localparam logic [31:0] SEED  = 32'hACE1_2024;
  localparam int          DEPTH = 1 << AW;
  localparam int          NWR   = (RP + 1) * DEPTH;
  // {tamper mask, pulse length}
  localparam logic [7:0] VEC [0:4] = '{8'h11, 8'h23, 8'h41, 8'h82, 8'hA1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT-1:0] tamper = '0;
  logic rdlock = 1'b0;
  logic mem_we, busy, done, tev;
  logic [AW-1:0] mem_addr, rd_addr, mem_rd_addr;
  logic [DW-1:0] mem_wdata, mem_rd_data, host_rd_data;
  logic [DW-1:0] mem [DEPTH];

  int checks = 0, errors = 0, wr_count = 0, cyc = 0;
  logic [31:0] exp_rnd = SEED;

  always #4 clk = ~clk;

  zeroize_ctrl #(.N_TAMPER(NT), .ADDR_W(AW), .DATA_W(DW), .RAND_PASSES(RP), .SEED(SEED)) dut (
    .clk(clk), .rst_n(rst_n), .tamper_i(tamper), .rdlock_i(rdlock),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .host_rd_addr_i(rd_addr), .mem_rd_addr_o(mem_rd_addr),
    .mem_rd_data_i(mem_rd_data), .host_rd_data_o(host_rd_data),
    .busy_o(busy), .done_o(done), .tamper_event_o(tev));

  assign rd_addr     = 6'd5;
  assign mem_rd_data = mem[mem_rd_addr];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Galois step written out bit-mask style
  function automatic logic [31:0] adv(input logic [31:0] s);
    return (s >> 1) ^ ({32{s[0]}} & 32'h8020_0003);
  endfunction

  // write monitor: R3 R4 R5
  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n && mem_we) begin
      if (wr_count >= NWR) chk(1'b0, "R8 extra write", wr_count, NWR);
      else begin
        chk(mem_addr == AW'(wr_count % DEPTH), "R5 address order", mem_addr, wr_count % DEPTH);
        if (wr_count / DEPTH < RP) begin
          chk(mem_wdata == exp_rnd, "R4 random data", mem_wdata, exp_rnd);
          exp_rnd = adv(exp_rnd);
        end else chk(mem_wdata == '0, "R3 final zero pass", mem_wdata, 0);
      end
      mem[mem_addr] = mem_wdata;
      wr_count++;
    end
  end

  task automatic reset_and_load();
    rst_n = 1'b0; tamper = '0; rdlock = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !tev && !mem_we, "R10 reset state", {busy, done, tev, mem_we}, 0);
    for (int i = 0; i < DEPTH; i++) mem[i] = 32'h5A00_0000 | (i * 32'h0101);
    wr_count = 0; exp_rnd = SEED;
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_rd_data == mem[5], "R6 open read", host_rd_data, mem[5]);
  endtask

  task automatic run_erase(input logic [3:0] mask, input int len);
    bit all_zero;
    reset_and_load();
    tamper = mask;
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk);
      if (c == len) tamper = '0;
      if (c < 3) chk(!busy && !tev, "R1 sync latency low", {busy, tev}, 0);
      else       chk(busy && tev, "R1 erase started", {busy, tev}, 2'b11);
    end
    tamper = '0;
    repeat (70) @(negedge clk);
    chk(host_rd_data == '0, "R6 read blocked in erase", host_rd_data, 0);
    tamper = ~mask; @(negedge clk); tamper = '0;
    for (int g = 0; g < 2000 && !done; g++) @(negedge clk);
    chk(done && !busy, "R9 done and idle", {done, busy}, 2'b10);
    chk(wr_count == NWR, "R3 write count", wr_count, NWR);
    all_zero = 1'b1;
    for (int i = 0; i < DEPTH; i++) if (mem[i] != '0) all_zero = 1'b0;
    chk(all_zero, "R3 memory zeroed", all_zero, 1);
    chk(tev, "R2 event sticky", tev, 1);
    tamper = mask; @(negedge clk); tamper = '0;
    repeat (10) @(negedge clk);
    chk(done && wr_count == NWR, "R8 no restart after done", wr_count, NWR);
    chk(host_rd_data == '0, "R6 read blocked after erase", host_rd_data, 0);
  endtask

  initial begin
    for (int v = 0; v < 5; v++) run_erase(VEC[v][7:4], int'(VEC[v][3:0]));

    // R7: lock alone
    reset_and_load();
    rdlock = 1'b1; @(negedge clk); rdlock = 1'b0;
    chk(host_rd_data == '0, "R7 lock blocks read", host_rd_data, 0);
    repeat (20) @(negedge clk);
    chk(host_rd_data == '0, "R7 lock sticky", host_rd_data, 0);
    chk(!busy && !tev && wr_count == 0, "R7 no erase from lock", wr_count, 0);
    chk(mem[5] == (32'h5A00_0000 | 32'h0505), "R7 memory untouched", mem[5], 32'h5A00_0505);

    // R10/R6: reset clears lock
    reset_and_load();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule